// File: doc/BRIEF.md
# Dual-Input Cascadable Up/Down Counter

This block is a binary counter with two count lines in place of a clock and a direction pin. A low-to-high transition on the up line adds one to the count, and a low-to-high transition on the down line subtracts one. Each line counts only while the other line is held high. A level-sensitive preset copies a data word onto the outputs, and a level-sensitive clear forces them to zero. Both act on the outputs at once, without waiting for the clock.

The two count lines are asynchronous to the chip. Each passes through a synchronizer on a free-running system clock, and the counter acts on the rising edges that the synchronizer detects. Two flags support chaining. The active-low carry flag is low while the count is at its maximum and the up line is low. The active-low borrow flag is low while the count is zero and the down line is low. Both flags are combinational. To build a wider counter from identical stages, wire a stage's carry to the next stage's up line and its borrow to the next stage's down line.

Top module: `updn_counter`

## Requirements
- R1: A detected rising edge on `up_i` increments the count by one, provided `dn_i` was high in both the sample that shows the edge and the sample before it.
- R2: A detected rising edge on `dn_i` decrements the count by one, provided `up_i` was high in both the sample that shows the edge and the sample before it.
- R3: The count wraps around. Counting up from all ones gives zero, and counting down from zero gives all ones.
- R4: The count does not change when a line rises while the other line is low, nor when both lines rise in the same sample.
- R5: With SYNC_STAGES=2, an input change made between clock edges changes `q_o` after the third rising clock edge that follows it, and not earlier.
- R6: While `load_ni` is low and `clr_i` is low, `q_o` equals `data_i` without waiting for a clock edge. If `load_ni` stays low across at least one clock edge, the counter keeps that value after release. A count edge detected during the load is discarded.
- R7: While `clr_i` is high, `q_o` is zero without waiting for a clock edge, even if `load_ni` is low. A counter that is cleared across a clock edge holds zero after release.
- R8: `borrow_no` is low exactly when `q_o` is zero and `dn_i` is low. Otherwise it is high.
- R9: `carry_no` is low exactly when `q_o` is all ones and `up_i` is low. Otherwise it is high.
- R10: Two stages share a clock. The lower stage's `carry_no` drives the upper stage's `up_i`, and its `borrow_no` drives the upper stage's `dn_i`. Counted this way, the pair counts as one 8-bit counter, and both stages change on the same clock edge.
- R11: While `rst_ni` is low, the count is zero and the synchronizers hold the idle-high level. Releasing reset with both lines high counts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock that samples the count lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Count-up line; counts on its rising edge |
| dn_i | input | 1 | Count-down line; counts on its rising edge |
| load_ni | input | 1 | Active-low preset |
| clr_i | input | 1 | Active-high clear; overrides the preset |
| data_i | input | WIDTH | Preset value |
| q_o | output | WIDTH | Count value |
| carry_no | output | 1 | Active-low carry flag for chaining |
| borrow_no | output | 1 | Active-low borrow flag for chaining |

## Verification
The bench builds the counter with WIDTH=4 and SYNC_STAGES=2. With WIDTH=4, both wrap points are one preset and one pulse away. With SYNC_STAGES=2, the bench can pin down which clock edge changes the output.

A second instance, chained to the first through its carry and borrow flags, exercises the multi-stage case in both directions across the stage boundary. Directed sequences also cover several points:
- lines that rise while the other line is low, and lines that rise together;
- count edges that arrive during a preset;
- a clear that overlaps a preset.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;
endpackage

// File: rtl/updn_edge_sync.sv
`timescale 1ns/1ps
module updn_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Reset to the idle-high level so that leaving reset counts nothing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/updn_step_decode.sv
`timescale 1ns/1ps
module updn_step_decode
  import updn_pkg::*;
(
  input  logic  up_lvl_i,
  input  logic  up_prev_i,
  input  logic  dn_lvl_i,
  input  logic  dn_prev_i,
  output step_e step_o
);
  logic up_rise, dn_rise, up_steady_hi, dn_steady_hi;

  assign up_rise      = up_lvl_i & ~up_prev_i;
  assign dn_rise      = dn_lvl_i & ~dn_prev_i;
  assign up_steady_hi = up_lvl_i & up_prev_i;
  assign dn_steady_hi = dn_lvl_i & dn_prev_i;

  always_comb begin
    step_o = STEP_HOLD;
    if (up_rise && dn_steady_hi)      step_o = STEP_INC;
    else if (dn_rise && up_steady_hi) step_o = STEP_DEC;
  end
endmodule

// File: rtl/updn_core.sv
`timescale 1ns/1ps
module updn_core
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  step_e            step_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (!load_ni) cnt_q <= data_i;
    else begin
      unique case (step_i)
        STEP_INC: cnt_q <= cnt_q + ONE;
        STEP_DEC: cnt_q <= cnt_q - ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  // Clear and preset reach the outputs without waiting for a clock edge
  always_comb begin
    if (clr_i)         q_o = '0;
    else if (!load_ni) q_o = data_i;
    else               q_o = cnt_q;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/updn_flags.sv
`timescale 1ns/1ps
module updn_flags #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic             carry_no,
  output logic             borrow_no
);
  localparam logic [WIDTH-1:0] TOP = '1;

  assign carry_no  = ~((q_i == TOP) & ~up_i);
  assign borrow_no = ~((q_i == '0) & ~dn_i);
endmodule

// File: rtl/updn_counter.sv
`timescale 1ns/1ps
module updn_counter
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             load_ni,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o,
  output logic             carry_no,
  output logic             borrow_no
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] line_raw, line_lvl, line_prev;
  logic [WIDTH-1:0]  cnt_q;
  step_e             step;

  assign line_raw = {dn_i, up_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    updn_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_raw[g]),
      .lvl_o  (line_lvl[g]),
      .prev_o (line_prev[g])
    );
  end

  updn_step_decode i_decode (
    .up_lvl_i  (line_lvl[0]),
    .up_prev_i (line_prev[0]),
    .dn_lvl_i  (line_lvl[1]),
    .dn_prev_i (line_prev[1]),
    .step_o    (step)
  );

  updn_core #(.WIDTH(WIDTH)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .load_ni (load_ni),
    .data_i  (data_i),
    .step_i  (step),
    .cnt_o   (cnt_q),
    .q_o     (q_o)
  );

  // Flags gate on the raw lines so a chained stage sees the edge in the same sample
  updn_flags #(.WIDTH(WIDTH)) i_flags (
    .q_i       (q_o),
    .up_i      (up_i),
    .dn_i      (dn_i),
    .carry_no  (carry_no),
    .borrow_no (borrow_no)
  );
endmodule

// File: rtl/updn_checker.sv
`timescale 1ns/1ps
module updn_checker #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             up_i,
  input logic             dn_i,
  input logic             load_ni,
  input logic             clr_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] q_o,
  input logic             carry_no,
  input logic             borrow_no,
  input logic [WIDTH-1:0] cnt_i
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] TOP = '1;

  assert_clear_output_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> q_o == '0);

  assert_clear_state_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_i == '0);

  assert_load_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_ni) |-> q_o == data_i);

  assert_load_state_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_ni) |=> cnt_i == $past(data_i));

  // R1 R2: between presets the count moves by at most one per clock
  assert_single_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_ni) |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + ONE
                             || cnt_i == $past(cnt_i) - ONE));

  assert_borrow_cond_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !borrow_no |-> (q_o == '0 && !dn_i));

  assert_carry_cond_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (q_o == TOP && !up_i));
endmodule

bind updn_counter updn_checker #(.WIDTH(WIDTH)) i_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .up_i      (up_i),
  .dn_i      (dn_i),
  .load_ni   (load_ni),
  .clr_i     (clr_i),
  .data_i    (data_i),
  .q_o       (q_o),
  .carry_no  (carry_no),
  .borrow_no (borrow_no),
  .cnt_i     (cnt_q)
);

// File: tb/test_updn_counter.sv
`timescale 1ns/1ps
module test_updn_counter;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         up_i = 1'b1, dn_i = 1'b1, load_ni = 1'b1, clr_i = 1'b0;
  logic [W-1:0] data_i = '0, data_hi = '0;
  logic [W-1:0] q_o, q_hi;
  logic         carry_no, borrow_no, carry_hi, borrow_hi;
  int           checks = 0, failures = 0;
  bit           done = 1'b0;

  always #10 clk_i = ~clk_i;

  updn_counter #(.WIDTH(W), .SYNC_STAGES(2)) i_updn_counter (
    .clk_i, .rst_ni, .up_i, .dn_i, .load_ni, .clr_i, .data_i,
    .q_o, .carry_no, .borrow_no
  );

  updn_counter #(.WIDTH(W), .SYNC_STAGES(2)) i_updn_counter_hi (
    .clk_i, .rst_ni, .up_i(carry_no), .dn_i(borrow_no), .load_ni, .clr_i,
    .data_i(data_hi), .q_o(q_hi), .carry_no(carry_hi), .borrow_no(borrow_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic pulse_up();
    up_i = 1'b0; wait_cyc(4);
    up_i = 1'b1; wait_cyc(4);
  endtask

  task automatic pulse_dn();
    dn_i = 1'b0; wait_cyc(4);
    dn_i = 1'b1; wait_cyc(4);
  endtask

  task automatic preset(input logic [W-1:0] lo, input logic [W-1:0] hi);
    data_i = lo; data_hi = hi; load_ni = 1'b0;
    wait_cyc(2);
    load_ni = 1'b1; wait_cyc(1);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; wait_cyc(2);
    rst_ni = 1'b1; wait_cyc(6);
    chk("R11 count after reset", q_o, 0);
    chk("R9 carry idle", carry_no, 1);
    chk("R8 borrow idle", borrow_no, 1);
  endtask

  task automatic t_count_up();
    pulse_up(); pulse_up(); pulse_up();
    chk("R1 three up pulses", q_o, 3);
  endtask

  task automatic t_latency();
    up_i = 1'b0; wait_cyc(4);
    up_i = 1'b1; wait_cyc(2);
    chk("R5 no change after two edges", q_o, 3);
    wait_cyc(1);
    chk("R5 change after third edge", q_o, 4);
  endtask

  task automatic t_count_down();
    pulse_dn(); pulse_dn();
    chk("R2 two down pulses", q_o, 2);
  endtask

  task automatic t_wrap();
    preset(4'd15, 4'd0);
    chk("R6 preset retained", q_o, 15);
    pulse_up();
    chk("R3 wrap up", q_o, 0);
    pulse_dn();
    chk("R3 wrap down", q_o, 15);
  endtask

  task automatic t_ignored();
    preset(4'd7, 4'd0);
    dn_i = 1'b0; wait_cyc(4);
    pulse_up();
    chk("R4 up while down low", q_o, 7);
    up_i = 1'b0; wait_cyc(4);
    up_i = 1'b1; dn_i = 1'b1; wait_cyc(4);
    chk("R4 both rise together", q_o, 7);
  endtask

  task automatic t_load();
    data_i = 4'd9; load_ni = 1'b0; #1;
    chk("R6 preset immediate", q_o, 9);
    @(negedge clk_i);
    pulse_up();
    chk("R6 count during preset", q_o, 9);
    load_ni = 1'b1; wait_cyc(4);
    chk("R6 edge discarded after release", q_o, 9);
  endtask

  task automatic t_clear();
    data_i = 4'd12; load_ni = 1'b0; clr_i = 1'b1; #1;
    chk("R7 clear over preset", q_o, 0);
    @(negedge clk_i); wait_cyc(1);
    clr_i = 1'b0; load_ni = 1'b1; wait_cyc(1);
    chk("R7 zero held after clear", q_o, 0);
  endtask

  task automatic t_flags();
    dn_i = 1'b0; #1;
    chk("R8 borrow low at zero", borrow_no, 0);
    @(negedge clk_i);
    dn_i = 1'b1; #1;
    chk("R8 borrow high when down high", borrow_no, 1);
    wait_cyc(4);
    chk("R2 wrap down from zero", q_o, 15);
    up_i = 1'b0; #1;
    chk("R9 carry low at max", carry_no, 0);
    chk("R8 borrow high at max", borrow_no, 1);
    @(negedge clk_i);
    up_i = 1'b1; #1;
    chk("R9 carry high when up high", carry_no, 1);
    wait_cyc(4);
    preset(4'd5, 4'd0);
    up_i = 1'b0; #1;
    chk("R9 carry high below max", carry_no, 1);
    @(negedge clk_i); up_i = 1'b1; wait_cyc(4);
  endtask

  task automatic t_cascade();
    preset(4'd15, 4'd0);
    pulse_up();
    chk("R10 low stage after carry", q_o, 0);
    chk("R10 high stage after carry", q_hi, 1);
    pulse_dn();
    chk("R10 low stage after borrow", q_o, 15);
    chk("R10 high stage after borrow", q_hi, 0);
    preset(4'd14, 4'd3);
    pulse_up(); pulse_up(); pulse_up();
    chk("R10 combined count up", {q_hi, q_o}, 8'h41);
  endtask

  initial begin
    wait_cyc(1);
    t_reset();
    t_count_up();
    t_latency();
    t_count_down();
    t_wrap();
    t_ignored();
    t_load();
    t_clear();
    t_flags();
    t_cascade();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule